// File: doc/BRIEF.md
# Multi-requester cache maintenance queue

This block is the register front end through which several processors post maintenance commands (invalidate, clean, flush) to a shared outer cache. Each processor has its own register port and is identified by the position of that port. All processors share one set of command registers: a mode word, a start address and a byte count. The first processor to write the mode word is granted exclusive right to these registers. While it holds that right, writes from the other processors to the command registers are dropped.

A command is registered when its owner reads its registration status word. At that read the command is either placed in a small in-order queue or turned away, and the owner's right is given up. A stub execution engine takes one queued command at a time. It presents the command on a strobe interface and keeps it active for a fixed number of cycles. Registration outcome, per-processor queue occupancy and the completion flag are all held separately for each processor. A read of the primitive entry register is held off until every queued command has been executed, which lets software wait for a drain.

Top module: `cmq_top`

## Requirements
- R1: After reset no port acknowledges, `op_start` is low, every register reads 0 except registration status, which reads 0x1 because no processor holds the right, and no command runs.
- R2: Mode word fields are scope in bits 18:17 (0 = address range, any other value = whole cache), notify enable in bit 15, and command in bits 3:0 (0 invalidate, 1 clean, 2 flush). While a command executes, the `op_*` outputs show its issuer, command, scope flag, address and size. For a whole-cache command, address and size show 0 whatever was written.
- R3: When no processor holds the access right, a mode-register write takes it. If several processors write the mode register in the same cycle, the lowest port index wins. The right stays with its holder until that holder reads its own registration status at offset 0x25C, and attempts by other processors do not take it away.
- R4: A processor that does not hold the right has its writes to mode (0x248), address (0x24C) and size (0x250) ignored, and any port reading those registers sees the holder's values. When that processor reads its registration status it gets bit 0 set (0x1).
- R5: If the holder reads registration status while the queue holds DEPTH commands, the read returns 0x2 (bit 1 set, bit 0 clear), the command is dropped and the right is released.
- R6: If the holder reads registration status while the queue has space, the read returns 0 and the command is queued. Commands start one at a time, in acceptance order, with a one-cycle `op_start` pulse, and each remains active for LAT cycles.
- R7: Queue status at offset 0x260 has, for the reading processor only, bit 1 = one of its commands is executing and bit 0 = one of its commands is waiting in the queue.
- R8: Queue status bit 2 is set when a command of that processor that has notify enabled finishes. It is set only for that processor and never for a command with notify off. Writing 1 to bit 2 clears it, and writes with bit 2 at 0 leave it unchanged.
- R9: Writes to the primitive entry register (0x244) are acknowledged at once. A read of it is not acknowledged until the queue is empty and no command is executing, and it returns 0.
- R10: A request is acknowledged with a one-cycle `bus_ack` pulse, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | NCPU | Per-port request, held until acknowledged |
| bus_we | input | NCPU | Per-port write enable |
| bus_addr | input | NCPU*AW | Per-port byte offset, port i in slice i |
| bus_wdata | input | NCPU*32 | Per-port write data |
| bus_ack | output | NCPU | Per-port acknowledge pulse |
| bus_rdata | output | NCPU*32 | Per-port read data, valid with acknowledge |
| op_start | output | 1 | Pulse as a command starts executing |
| op_cpu | output | 4 | Issuing port of the executing command |
| op_cmd | output | 4 | Command code of the executing command |
| op_whole | output | 1 | Executing command covers the whole cache |
| op_addr | output | 32 | Start address (0 for whole cache) |
| op_size | output | 32 | Byte count (0 for whole cache) |

## Verification
The hardest condition to reach is a full queue at the moment a registration commits. That needs the engine held on one command while other processors keep registering. The bench sets a long execution latency and posts six commands back to back from three ports, so the sixth commit is turned away. With the queue still full, it then checks per-processor occupancy and that the rejecting read released the right. Same-cycle contention for the right is reached by starting two mode writes from different ports on the same clock edge.

// File: rtl/cmq_pkg.sv
package cmq_pkg;

    localparam int DW      = 32;
    localparam int CPU_IDW = 4;
    localparam int CMD_W   = 4;

    localparam logic [31:0] OFF_PRIM  = 32'h0000_0244;
    localparam logic [31:0] OFF_MODE  = 32'h0000_0248;
    localparam logic [31:0] OFF_ADDR  = 32'h0000_024C;
    localparam logic [31:0] OFF_SIZE  = 32'h0000_0250;
    localparam logic [31:0] OFF_REGST = 32'h0000_025C;
    localparam logic [31:0] OFF_QSTAT = 32'h0000_0260;

    localparam int SCOPE_LSB  = 17;
    localparam int NOTIFY_BIT = 15;
    localparam logic [31:0] MODE_MASK = 32'h0006_800F;

    localparam int RS_DENY_BIT = 0;
    localparam int RS_FULL_BIT = 1;
    localparam int QS_WAIT_BIT = 0;
    localparam int QS_RUN_BIT  = 1;
    localparam int QS_DONE_BIT = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PRIM,
        SEL_MODE,
        SEL_ADDR,
        SEL_SIZE,
        SEL_REGST,
        SEL_QSTAT
    } cmq_sel_e;

    typedef struct packed {
        logic [CPU_IDW-1:0] cpu;
        logic               whole;
        logic               notify;
        logic [CMD_W-1:0]   cmd;
        logic [DW-1:0]      addr;
        logic [DW-1:0]      size;
    } cmq_entry_t;

    function automatic cmq_sel_e decode_sel(input logic [31:0] off);
        cmq_sel_e s;
        case (off)
            OFF_PRIM:  s = SEL_PRIM;
            OFF_MODE:  s = SEL_MODE;
            OFF_ADDR:  s = SEL_ADDR;
            OFF_SIZE:  s = SEL_SIZE;
            OFF_REGST: s = SEL_REGST;
            OFF_QSTAT: s = SEL_QSTAT;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic cmq_entry_t make_entry(input logic [CPU_IDW-1:0] id,
                                              input logic [31:0] mode,
                                              input logic [DW-1:0] addr,
                                              input logic [DW-1:0] size);
        cmq_entry_t e;
        e.cpu    = id;
        e.whole  = (mode[SCOPE_LSB +: 2] != 2'd0);
        e.notify = mode[NOTIFY_BIT];
        e.cmd    = mode[CMD_W-1:0];
        e.addr   = e.whole ? '0 : addr;
        e.size   = e.whole ? '0 : size;
        return e;
    endfunction

endpackage

// File: rtl/cmq_port.sv
module cmq_port
    import cmq_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          wbit_done,
    input  logic          owner_me,
    input  logic          q_full,
    input  logic          drained,
    input  logic          run_me,
    input  logic          wait_me,
    input  logic          done_set,
    input  logic [31:0]   sh_mode,
    input  logic [DW-1:0] sh_addr,
    input  logic [DW-1:0] sh_size,
    output logic          ack,
    output logic [31:0]   rdata,
    output logic          wr_mode,
    output logic          wr_addr,
    output logic          wr_size,
    output logic          rd_regst
);

    logic        ack_q;
    logic [31:0] rdata_q;
    logic        done_q;
    logic [31:0] addr_ext;
    cmq_sel_e    sel;
    logic        hit;
    logic        stall;
    logic        take;
    logic [31:0] rd_val;

    assign addr_ext = {{(32-AW){1'b0}}, addr};
    assign sel      = decode_sel(addr_ext);
    assign hit      = req & ~ack_q;
    assign stall    = hit & ~we & (sel == SEL_PRIM) & ~drained;
    assign take     = hit & ~stall;

    assign wr_mode  = take &  we & (sel == SEL_MODE);
    assign wr_addr  = take &  we & (sel == SEL_ADDR);
    assign wr_size  = take &  we & (sel == SEL_SIZE);
    assign rd_regst = take & ~we & (sel == SEL_REGST);

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_MODE:  rd_val = sh_mode;
            SEL_ADDR:  rd_val = sh_addr;
            SEL_SIZE:  rd_val = sh_size;
            SEL_REGST: begin
                rd_val[RS_FULL_BIT] = owner_me & q_full;
                rd_val[RS_DENY_BIT] = ~owner_me;
            end
            SEL_QSTAT: begin
                rd_val[QS_DONE_BIT] = done_q;
                rd_val[QS_RUN_BIT]  = run_me;
                rd_val[QS_WAIT_BIT] = wait_me;
            end
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            ack_q <= take;
            if (take) begin
                rdata_q <= we ? '0 : rd_val;
            end
            if (done_set) begin
                done_q <= 1'b1;
            end else if (take && we && (sel == SEL_QSTAT) && wbit_done) begin
                done_q <= 1'b0;
            end
        end
    end

    assign ack   = ack_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/cmq_lock.sv
module cmq_lock
    import cmq_pkg::*;
#(
    parameter int NCPU = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCPU-1:0]    mode_wr,
    input  logic [NCPU-1:0]    regst_rd,
    output logic [NCPU-1:0]    own_vec,
    output logic [NCPU-1:0]    win_vec,
    output logic               owner_valid,
    output logic [CPU_IDW-1:0] owner_id
);

    logic [CPU_IDW-1:0] win_id;
    logic               release_now;

    always_comb begin
        logic found;
        found   = 1'b0;
        win_vec = '0;
        win_id  = '0;
        for (int i = 0; i < NCPU; i++) begin
            if (!owner_valid && mode_wr[i] && !found) begin
                win_vec[i] = 1'b1;
                win_id     = CPU_IDW'(i);
                found      = 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < NCPU; g++) begin : g_own
            assign own_vec[g] = owner_valid && (owner_id == CPU_IDW'(g));
        end
    endgenerate

    assign release_now = owner_valid && (|(regst_rd & own_vec));

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_valid <= 1'b0;
            owner_id    <= '0;
        end else if (release_now) begin
            owner_valid <= 1'b0;
        end else if (|win_vec) begin
            owner_valid <= 1'b1;
            owner_id    <= win_id;
        end
    end

endmodule

// File: rtl/cmq_fifo.sv
module cmq_fifo
    import cmq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int NCPU  = 3,
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  cmq_entry_t      pdata,
    input  logic            pop,
    output cmq_entry_t      head,
    output logic            empty,
    output logic            full,
    output logic [CNTW-1:0] count,
    output logic [NCPU-1:0] waiting
);

    cmq_entry_t       mem [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [PTRW-1:0]  wr_ptr;
    logic [PTRW-1:0]  rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNTW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PTRW-1:0] next_ptr(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            vld    <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= pdata;
                wr_ptr      <= next_ptr(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= next_ptr(rd_ptr);
            end
            for (int k = 0; k < DEPTH; k++) begin
                if (do_push && (wr_ptr == PTRW'(k))) begin
                    vld[k] <= 1'b1;
                end else if (do_pop && (rd_ptr == PTRW'(k))) begin
                    vld[k] <= 1'b0;
                end
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    generate
        for (genvar c = 0; c < NCPU; c++) begin : g_wait
            logic [DEPTH-1:0] match;
            for (genvar k = 0; k < DEPTH; k++) begin : g_slot
                assign match[k] = vld[k] && (mem[k].cpu == CPU_IDW'(c));
            end
            assign waiting[c] = |match;
        end
    endgenerate

endmodule

// File: rtl/cmq_engine.sv
module cmq_engine
    import cmq_pkg::*;
#(
    parameter int LAT = 8,
    localparam int CNTW = (LAT > 1) ? $clog2(LAT) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       q_empty,
    input  cmq_entry_t head,
    output logic       pop,
    output logic       busy,
    output logic       start,
    output logic       done,
    output cmq_entry_t cur
);

    logic [CNTW-1:0] remain;

    assign pop = !busy && !q_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            start  <= 1'b0;
            done   <= 1'b0;
            remain <= '0;
            cur    <= '0;
        end else begin
            start <= pop;
            done  <= 1'b0;
            if (pop) begin
                cur    <= head;
                busy   <= 1'b1;
                remain <= CNTW'(LAT - 1);
            end else if (busy) begin
                if (remain == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cmq_top.sv
module cmq_top
    import cmq_pkg::*;
#(
    parameter int NCPU  = 3,
    parameter int AW    = 12,
    parameter int DEPTH = 4,
    parameter int LAT   = 8,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCPU-1:0]      bus_req,
    input  logic [NCPU-1:0]      bus_we,
    input  logic [NCPU*AW-1:0]   bus_addr,
    input  logic [NCPU*DW-1:0]   bus_wdata,
    output logic [NCPU-1:0]      bus_ack,
    output logic [NCPU*DW-1:0]   bus_rdata,
    output logic                 op_start,
    output logic [CPU_IDW-1:0]   op_cpu,
    output logic [CMD_W-1:0]     op_cmd,
    output logic                 op_whole,
    output logic [DW-1:0]        op_addr,
    output logic [DW-1:0]        op_size
);

    logic [NCPU-1:0]    wr_mode;
    logic [NCPU-1:0]    wr_addr;
    logic [NCPU-1:0]    wr_size;
    logic [NCPU-1:0]    rd_regst;
    logic [NCPU-1:0]    own_vec;
    logic [NCPU-1:0]    win_vec;
    logic               owner_valid;
    logic [CPU_IDW-1:0] owner_id;
    logic [NCPU-1:0]    wait_vec;
    logic [NCPU-1:0]    run_vec;
    logic [NCPU-1:0]    done_vec;

    logic [31:0]        mode_q;
    logic [DW-1:0]      addr_q;
    logic [DW-1:0]      size_q;

    cmq_entry_t         push_data;
    cmq_entry_t         head;
    cmq_entry_t         cur;
    logic               fifo_push;
    logic               fifo_pop;
    logic               fifo_empty;
    logic               fifo_full;
    logic [CNTW-1:0]    fifo_cnt;
    logic               eng_busy;
    logic               eng_done;
    logic               drained;

    assign drained = fifo_empty && !eng_busy;

    cmq_lock #(.NCPU(NCPU)) u_lock (
        .clk         (clk),
        .rst         (rst),
        .mode_wr     (wr_mode),
        .regst_rd    (rd_regst),
        .own_vec     (own_vec),
        .win_vec     (win_vec),
        .owner_valid (owner_valid),
        .owner_id    (owner_id)
    );

    generate
        for (genvar g = 0; g < NCPU; g++) begin : g_port
            assign run_vec[g]  = eng_busy && (cur.cpu == CPU_IDW'(g));
            assign done_vec[g] = eng_done && cur.notify && (cur.cpu == CPU_IDW'(g));

            cmq_port #(.AW(AW)) u_port (
                .clk       (clk),
                .rst       (rst),
                .req       (bus_req[g]),
                .we        (bus_we[g]),
                .addr      (bus_addr[g*AW +: AW]),
                .wbit_done (bus_wdata[g*DW + QS_DONE_BIT]),
                .owner_me  (own_vec[g]),
                .q_full    (fifo_full),
                .drained   (drained),
                .run_me    (run_vec[g]),
                .wait_me   (wait_vec[g]),
                .done_set  (done_vec[g]),
                .sh_mode   (mode_q),
                .sh_addr   (addr_q),
                .sh_size   (size_q),
                .ack       (bus_ack[g]),
                .rdata     (bus_rdata[g*DW +: DW]),
                .wr_mode   (wr_mode[g]),
                .wr_addr   (wr_addr[g]),
                .wr_size   (wr_size[g]),
                .rd_regst  (rd_regst[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            addr_q <= '0;
            size_q <= '0;
        end else begin
            for (int i = 0; i < NCPU; i++) begin
                if (wr_mode[i] && (own_vec[i] || win_vec[i])) begin
                    mode_q <= bus_wdata[i*DW +: DW] & MODE_MASK;
                end
                if (wr_addr[i] && own_vec[i]) begin
                    addr_q <= bus_wdata[i*DW +: DW];
                end
                if (wr_size[i] && own_vec[i]) begin
                    size_q <= bus_wdata[i*DW +: DW];
                end
            end
        end
    end

    assign push_data = make_entry(owner_id, mode_q, addr_q, size_q);
    assign fifo_push = owner_valid && (|(rd_regst & own_vec)) && !fifo_full;

    cmq_fifo #(.DEPTH(DEPTH), .NCPU(NCPU)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (fifo_push),
        .pdata   (push_data),
        .pop     (fifo_pop),
        .head    (head),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .count   (fifo_cnt),
        .waiting (wait_vec)
    );

    cmq_engine #(.LAT(LAT)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .q_empty (fifo_empty),
        .head    (head),
        .pop     (fifo_pop),
        .busy    (eng_busy),
        .start   (op_start),
        .done    (eng_done),
        .cur     (cur)
    );

    assign op_cpu   = cur.cpu;
    assign op_cmd   = cur.cmd;
    assign op_whole = cur.whole;
    assign op_addr  = cur.addr;
    assign op_size  = cur.size;

endmodule

// File: rtl/cmq_checker.sv
module cmq_checker
    import cmq_pkg::*;
#(
    parameter int NCPU  = 3,
    parameter int DEPTH = 4,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [NCPU-1:0]    bus_ack,
    input logic [NCPU-1:0]    own_vec,
    input logic               owner_valid,
    input logic [CPU_IDW-1:0] owner_id,
    input logic [NCPU-1:0]    rd_regst,
    input logic               op_start,
    input logic               eng_busy,
    input logic [CNTW-1:0]    fifo_cnt
);

    // R3: never more than one holder of the access right
    a_r3_single_owner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(own_vec));

    // R3: the right stays put until its holder reads registration status
    a_r3_owner_kept: assert property (@(posedge clk) disable iff (rst)
        (owner_valid && !(|(rd_regst & own_vec))) |=> (owner_valid && $stable(owner_id)));

    // R5: queue occupancy never exceeds its depth
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNTW'(DEPTH));

    // R6: a start pulse only begins a new execution interval
    a_r6_start_rises: assert property (@(posedge clk) disable iff (rst)
        op_start |-> $rose(eng_busy));

    // R6: every execution interval is announced by a start pulse
    a_r6_busy_announced: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_busy) |-> op_start);

    // R10: acknowledge is a single-cycle pulse on every port
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        (bus_ack & $past(bus_ack)) == '0);

endmodule

bind cmq_top cmq_checker #(.NCPU(NCPU), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_ack     (bus_ack),
    .own_vec     (own_vec),
    .owner_valid (owner_valid),
    .owner_id    (owner_id),
    .rd_regst    (rd_regst),
    .op_start    (op_start),
    .eng_busy    (eng_busy),
    .fifo_cnt    (fifo_cnt)
);

// File: tb/tb_cmq_top.sv
module tb_cmq_top;
    import cmq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCPU  = 3;
    localparam int AW    = 12;
    localparam int DEPTH = 4;
    localparam int LAT   = 100;

    localparam logic [AW-1:0] A_PRIM  = AW'(OFF_PRIM);
    localparam logic [AW-1:0] A_MODE  = AW'(OFF_MODE);
    localparam logic [AW-1:0] A_ADDR  = AW'(OFF_ADDR);
    localparam logic [AW-1:0] A_SIZE  = AW'(OFF_SIZE);
    localparam logic [AW-1:0] A_REGST = AW'(OFF_REGST);
    localparam logic [AW-1:0] A_QSTAT = AW'(OFF_QSTAT);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCPU-1:0]    req = '0;
    logic [NCPU-1:0]    we  = '0;
    logic [AW-1:0]      addr_a [NCPU];
    logic [31:0]        wd_a   [NCPU];
    logic [NCPU*AW-1:0] bus_addr;
    logic [NCPU*32-1:0] bus_wdata;
    logic [NCPU-1:0]    bus_ack;
    logic [NCPU*32-1:0] bus_rdata;
    logic               op_start;
    logic [CPU_IDW-1:0] op_cpu;
    logic [CMD_W-1:0]   op_cmd;
    logic               op_whole;
    logic [31:0]        op_addr;
    logic [31:0]        op_size;

    int tests = 0;
    int fails = 0;
    int n_ops = 0;
    bit expired = 0;
    logic [31:0] log_cpu   [32];
    logic [31:0] log_cmd   [32];
    logic [31:0] log_whole [32];
    logic [31:0] log_addr  [32];
    logic [31:0] log_size  [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCPU; i++) begin
            bus_addr[i*AW +: AW]  = addr_a[i];
            bus_wdata[i*32 +: 32] = wd_a[i];
        end
    end

    cmq_top #(.NCPU(NCPU), .AW(AW), .DEPTH(DEPTH), .LAT(LAT)) dut (
        .clk(clk), .rst(rst),
        .bus_req(req), .bus_we(we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .op_start(op_start), .op_cpu(op_cpu), .op_cmd(op_cmd),
        .op_whole(op_whole), .op_addr(op_addr), .op_size(op_size)
    );

    always @(negedge clk) begin
        if (!rst && op_start && n_ops < 32) begin
            log_cpu[n_ops]   = 32'(op_cpu);
            log_cmd[n_ops]   = 32'(op_cmd);
            log_whole[n_ops] = 32'(op_whole);
            log_addr[n_ops]  = op_addr;
            log_size[n_ops]  = op_size;
            n_ops = n_ops + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input int c, input logic w, input logic [AW-1:0] a,
                          input logic [31:0] d, output logic [31:0] q);
        int k = 0;
        @(negedge clk);
        req[c] = 1'b1; we[c] = w; addr_a[c] = a; wd_a[c] = d;
        do begin
            @(negedge clk);
            k++;
        end while (!bus_ack[c] && k < 5000);
        q = bus_rdata[c*32 +: 32];
        req[c] = 1'b0; we[c] = 1'b0;
    endtask

    task automatic wr(input int c, input logic [AW-1:0] a, input logic [31:0] d);
        logic [31:0] q;
        access(c, 1'b1, a, d, q);
    endtask

    task automatic rd(input int c, input logic [AW-1:0] a, output logic [31:0] q);
        access(c, 1'b0, a, 32'h0, q);
    endtask

    task automatic post(input int c, input logic [31:0] m, input logic [31:0] a,
                        input logic [31:0] s, output logic [31:0] st);
        wr(c, A_MODE, m);
        wr(c, A_ADDR, a);
        wr(c, A_SIZE, s);
        rd(c, A_REGST, st);
    endtask

    task automatic wait_ops(input int n);
        int k = 0;
        while (n_ops < n && k < 5000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] q;
        chk("R1 ack idle", 32'(bus_ack), 32'h0);
        chk("R1 op_start idle", 32'(op_start), 32'h0);
        rd(0, A_QSTAT, q);   chk("R1 qstat", q, 32'h0);
        rd(1, A_REGST, q);   chk("R1 regst unowned", q, 32'h1);
        rd(2, A_MODE, q);    chk("R1 mode reg", q, 32'h0);
        chk("R1 no ops", 32'(n_ops), 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] q;
        int k = 0;
        post(0, 32'h0000_8002, 32'h1000, 32'h80, q);
        chk("R6 accept status", q, 32'h0);
        wait_ops(1);
        chk("R6 one op", 32'(n_ops), 32'h1);
        chk("R2 cpu", log_cpu[0], 32'h0);
        chk("R2 cmd", log_cmd[0], 32'h2);
        chk("R2 range", log_whole[0], 32'h0);
        chk("R2 addr", log_addr[0], 32'h1000);
        chk("R2 size", log_size[0], 32'h80);
        do begin rd(0, A_QSTAT, q); k++; end while (!q[2] && k < 500);
        chk("R8 done set", q, 32'h4);
        wr(0, A_QSTAT, 32'h3);
        rd(0, A_QSTAT, q);   chk("R8 clear needs bit2", q, 32'h4);
        wr(0, A_QSTAT, 32'h4);
        rd(0, A_QSTAT, q);   chk("R8 w1c", q, 32'h0);
        rd(0, 12'h100, q);   chk("R10 unmapped", q, 32'h0);
        @(negedge clk);
        chk("R10 ack dropped", 32'(bus_ack), 32'h0);
    endtask

    task automatic t_whole();
        logic [31:0] q;
        post(1, 32'h0002_0000, 32'h55, 32'h99, q);
        chk("R6 whole accept", q, 32'h0);
        wait_ops(2);
        chk("R2 whole cpu", log_cpu[1], 32'h1);
        chk("R2 whole cmd", log_cmd[1], 32'h0);
        chk("R2 whole flag", log_whole[1], 32'h1);
        chk("R2 whole addr zero", log_addr[1], 32'h0);
        chk("R2 whole size zero", log_size[1], 32'h0);
        rd(1, A_PRIM, q);    chk("R9 prim read", q, 32'h0);
        rd(1, A_QSTAT, q);   chk("R8 no notify", q, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] q;
        wr(0, A_MODE, 32'h0000_8001);
        wr(0, A_ADDR, 32'h2000);
        wr(1, A_MODE, 32'h2);
        wr(1, A_ADDR, 32'hDEAD);
        rd(2, A_MODE, q);    chk("R4 mode kept", q, 32'h0000_8001);
        rd(2, A_ADDR, q);    chk("R4 addr kept", q, 32'h2000);
        rd(1, A_REGST, q);   chk("R4 denied", q, 32'h1);
        wr(0, A_SIZE, 32'h40);
        rd(0, A_REGST, q);   chk("R3 holder commits", q, 32'h0);
        wait_ops(3);
        chk("R3 op cpu", log_cpu[2], 32'h0);
        chk("R3 op cmd", log_cmd[2], 32'h1);
        chk("R3 op addr", log_addr[2], 32'h2000);
        chk("R3 op size", log_size[2], 32'h40);
        post(1, 32'h2, 32'h3000, 32'h40, q);
        chk("R3 released", q, 32'h0);
        rd(0, A_PRIM, q);
        wr(0, A_QSTAT, 32'h4);
        chk("R6 four ops", 32'(n_ops), 32'h4);
    endtask

    task automatic t_simul();
        logic [31:0] q;
        fork
            wr(1, A_MODE, 32'h1);
            wr(2, A_MODE, 32'h2);
        join
        rd(0, A_MODE, q);    chk("R3 lower index wins", q, 32'h1);
        rd(2, A_REGST, q);   chk("R3 loser denied", q, 32'h1);
        wr(1, A_ADDR, 32'h4000);
        wr(1, A_SIZE, 32'h20);
        rd(1, A_REGST, q);   chk("R3 winner commits", q, 32'h0);
        wait_ops(5);
        chk("R3 winner op", log_cpu[4], 32'h1);
        chk("R3 winner addr", log_addr[4], 32'h4000);
        rd(1, A_PRIM, q);
    endtask

    task automatic t_full();
        logic [31:0] q;
        int base = n_ops;
        post(0, 32'h0000_8002, 32'hA000, 32'h40, q); chk("R6 A", q, 32'h0);
        post(0, 32'h0000_8002, 32'hB000, 32'h40, q); chk("R6 B", q, 32'h0);
        post(0, 32'h0000_8002, 32'hC000, 32'h40, q); chk("R6 C", q, 32'h0);
        post(1, 32'h1, 32'hD000, 32'h40, q);         chk("R6 D", q, 32'h0);
        post(1, 32'h1, 32'hE000, 32'h40, q);         chk("R6 E", q, 32'h0);
        post(2, 32'h1, 32'hF000, 32'h40, q);         chk("R5 full reject", q, 32'h2);
        rd(0, A_QSTAT, q);   chk("R7 cpu0 run+wait", q, 32'h3);
        rd(1, A_QSTAT, q);   chk("R7 cpu1 wait", q, 32'h1);
        rd(2, A_QSTAT, q);   chk("R7 cpu2 none", q, 32'h0);
        post(0, 32'h1, 32'h7000, 32'h40, q);         chk("R5 right released", q, 32'h2);
        wr(2, A_PRIM, 32'h8);
        rd(2, A_PRIM, q);    chk("R9 drain read", q, 32'h0);
        chk("R9 all executed", 32'(n_ops), 32'(base + 5));
        rd(0, A_QSTAT, q);   chk("R8 cpu0 done", q, 32'h4);
        rd(1, A_QSTAT, q);   chk("R8 cpu1 no done", q, 32'h0);
        chk("R6 order A", log_addr[base],     32'hA000);
        chk("R6 order B", log_addr[base + 1], 32'hB000);
        chk("R6 order C", log_addr[base + 2], 32'hC000);
        chk("R6 order D", log_addr[base + 3], 32'hD000);
        chk("R6 order E", log_addr[base + 4], 32'hE000);
    endtask

    initial begin
        for (int i = 0; i < NCPU; i++) begin
            addr_a[i] = '0;
            wd_a[i]   = '0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_whole();
        t_lock();
        t_simul();
        t_full();
        if (!expired) begin
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        expired = 1;
        tests++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule